// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address front end of a synchronous burst memory. On every rising clock edge it samples three chip-select inputs, two address strobes (one driven by a processor, one by a memory controller) and an advance input. An accepted strobe with the device selected captures the full word address. The low bits of that address seed a small burst counter. Later advance cycles walk the counter through a four-beat burst, while the upper address bits stay fixed.

The burst counter walks in one of two orders. A static order-select input picks either a linear sequence (add one, wrapping) or an interleaved sequence (the start value XORed with the beat count). The block has three outputs: the current word address, a flag that shows whether the device is selected, and a one-cycle flag that marks the first cycle of each new access. Storage, data, byte enables and output-enable handling belong to other blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: When an accepted strobe is seen with all chip selects active (cs1_n low, cs2 high, cs3_n low), the next cycle shows word_addr equal to the sampled addr_in and selected high.
- R2: When both strobes are low and cs1_n is low, the edge is handled as one processor-strobe capture: the same result as R1, with a single new_access pulse.
- R3: While cs1_n is high, a low processor strobe has no effect. If the controller strobe is high, no capture takes place, new_access stays low and the upper address bits are unchanged.
- R4: new_access is high for exactly the one cycle after each capture and is low in every other cycle.
- R5: With order_sel low (linear), after a capture with low bits s the low two address bits go s, s+1, s+2, s+3 modulo 4 on successive advance cycles, and keep wrapping.
- R6: With order_sel high (interleaved), the low two bits on the n-th advance after a capture with start s equal s XOR (n modulo 4). For example, a start of 1 gives 1,0,3,2.
- R7: During a burst, word_addr[15:2] stays equal to the captured upper address bits. Only bits [1:0] change.
- R8: On an edge with no accepted strobe and adv_n high, word_addr and selected keep their values.
- R9: An accepted strobe seen while the chip selects are not all active drives selected low. While the block is deselected, adv_n low leaves word_addr unchanged.
- R10: While rst_n is low, selected and new_access are low and word_addr is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, higher priority |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Address sampled on a capture |
| word_addr | output | ADDR_W | Current word address |
| selected | output | 1 | Device selected flag |
| new_access | output | 1 | High for the first cycle of a new access |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 2-bit burst counter. With these values, every start value in both burst orders can be walked through more than one full wrap of four beats. The bench also sweeps all eight chip-select patterns against all four strobe patterns and both advance levels, each applied from a known mid-burst state. That sweep reaches every priority, gating and deselect case.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // Action chosen for a clock edge
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_DESEL = 2'd3
   } seq_act_e;
endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
   import burst_seq_pkg::*;
(
   input  logic     cs1_n,
   input  logic     cs2,
   input  logic     cs3_n,
   input  logic     strb_cpu_n,
   input  logic     strb_ctl_n,
   input  logic     adv_n,
   input  logic     selected,
   output seq_act_e act
);
   logic enables_ok;
   logic cpu_hit;
   logic ctl_hit;

   assign enables_ok = !cs1_n && cs2 && !cs3_n;
   // processor strobe is gated by cs1 and wins over the controller strobe
   assign cpu_hit    = !strb_cpu_n && !cs1_n;
   assign ctl_hit    = !strb_ctl_n && !cpu_hit;

   always_comb begin
      if (cpu_hit || ctl_hit) begin
         act = enables_ok ? ACT_LOAD : ACT_DESEL;
      end else if (!adv_n && selected) begin
         act = ACT_STEP;
      end else begin
         act = ACT_HOLD;
      end
   end
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] base,
   input  logic [CNT_W-1:0] step,
   input  logic             order_sel,
   output logic [CNT_W-1:0] low
);
   generate
      if (CNT_W == 1) begin : g_single
         // one bit: both orders reduce to a toggle
         logic unused_sel;
         assign unused_sel = order_sel;
         assign low = base ^ step;
      end else begin : g_multi
         logic [CNT_W-1:0] lin;
         logic [CNT_W-1:0] ilv;
         assign lin = base + step;
         assign ilv = base ^ step;
         assign low = order_sel ? ilv : lin;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  seq_act_e                act,
   input  logic [ADDR_W-1:0]       addr_in,
   output logic [ADDR_W-CNT_W-1:0] hi,
   output logic [CNT_W-1:0]        base,
   output logic [CNT_W-1:0]        step,
   output logic                    sel,
   output logic                    fresh
);
   localparam int HI_W = ADDR_W - CNT_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi    <= '0;
         base  <= '0;
         step  <= '0;
         sel   <= 1'b0;
         fresh <= 1'b0;
      end else begin
         fresh <= 1'b0;
         unique case (act)
            ACT_LOAD: begin
               hi    <= addr_in[ADDR_W-1 -: HI_W];
               base  <= addr_in[CNT_W-1:0];
               step  <= '0;
               sel   <= 1'b1;
               fresh <= 1'b1;
            end
            ACT_DESEL: sel  <= 1'b0;
            ACT_STEP:  step <= step + CNT_W'(1);
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              adv_n,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] word_addr,
   output logic              selected,
   output logic              new_access
);
   localparam int HI_W = ADDR_W - CNT_W;

   initial begin
      assert (CNT_W >= 1 && CNT_W < ADDR_W)
         else $fatal(1, "burst_addr_seq: CNT_W must be in 1..ADDR_W-1");
   end

   seq_act_e         act;
   logic [HI_W-1:0]  hi;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] low;

   burst_strobe_arb u_arb (
      .cs1_n      (cs1_n),
      .cs2        (cs2),
      .cs3_n      (cs3_n),
      .strb_cpu_n (strb_cpu_n),
      .strb_ctl_n (strb_ctl_n),
      .adv_n      (adv_n),
      .selected   (selected),
      .act        (act)
   );

   burst_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .addr_in (addr_in),
      .hi      (hi),
      .base    (base),
      .step    (step),
      .sel     (selected),
      .fresh   (new_access)
   );

   burst_order_gen #(.CNT_W(CNT_W)) u_order (
      .base      (base),
      .step      (step),
      .order_sel (order_sel),
      .low       (low)
   );

   assign word_addr = {hi, low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              strb_cpu_n,
   input logic              strb_ctl_n,
   input logic              adv_n,
   input logic              order_sel,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] word_addr,
   input logic              selected,
   input logic              new_access
);
   logic en_ok;
   logic acc;
   assign en_ok = !cs1_n && cs2 && !cs3_n;
   assign acc   = (!strb_cpu_n && !cs1_n) || !strb_ctl_n;

   assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && en_ok) |=> (word_addr == $past(addr_in)) && selected);

   assert_dual_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_cpu_n && !strb_ctl_n && en_ok) |=> new_access && (word_addr == $past(addr_in)));

   assert_cpu_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs1_n && strb_ctl_n) |=> !new_access && $stable(word_addr[ADDR_W-1:CNT_W]));

   assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && en_ok) |=> !new_access);

   assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !adv_n && selected && !order_sel && $stable(order_sel)) |=>
      (word_addr[CNT_W-1:0] == CNT_W'($past(word_addr[CNT_W-1:0]) + 1'b1)));

   assert_ilv_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !adv_n && selected && order_sel) |=> (word_addr[0] != $past(word_addr[0])));

   assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !adv_n) |=> $stable(word_addr[ADDR_W-1:CNT_W]));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && adv_n && $stable(order_sel)) |=> $stable(word_addr) && $stable(selected));

   assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !en_ok) |=> !selected && !new_access);

   assert_desel_no_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !selected && $stable(order_sel)) |=> $stable(word_addr) && !selected);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
   logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] word_addr;
   logic          selected, new_access;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state, written from the requirements
   logic          m_sel = 1'b0;
   logic          m_new = 1'b0;
   logic [AW-1:0] m_cap = '0;
   logic [1:0]    m_step = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq u_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
      .order_sel(order_sel), .addr_in(addr_in),
      .word_addr(word_addr), .selected(selected), .new_access(new_access)
   );

   function automatic logic [AW-1:0] exp_addr();
      logic [1:0] lo;
      lo = order_sel ? (m_cap[1:0] ^ m_step) : (m_cap[1:0] + m_step);
      return {m_cap[AW-1:2], lo};
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic c1, input logic c2, input logic c3,
                      input logic cpu, input logic ctl, input logic adv,
                      input logic [AW-1:0] a, input string tag);
      logic en, hit;
      cs1_n = c1; cs2 = c2; cs3_n = c3;
      strb_cpu_n = cpu; strb_ctl_n = ctl; adv_n = adv; addr_in = a;
      @(posedge clk);
      en  = !c1 && c2 && !c3;
      hit = (!cpu && !c1) || !ctl;
      if (hit) begin
         if (en) begin
            m_sel = 1'b1; m_new = 1'b1; m_cap = a; m_step = '0;
         end else begin
            m_sel = 1'b0; m_new = 1'b0;
         end
      end else begin
         m_new = 1'b0;
         if (!adv && m_sel) m_step = m_step + 2'd1;
      end
      #1;
      check({tag, " addr"}, word_addr, exp_addr());
      check({tag, " selected"}, {15'd0, selected}, {15'd0, m_sel});
      check({tag, " new_access R4"}, {15'd0, new_access}, {15'd0, m_new});
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      check("R10 reset addr", word_addr, '0);
      check("R10 reset selected", {15'd0, selected}, 16'd0);
      check("R10 reset new_access", {15'd0, new_access}, 16'd0);
      rst_n = 1'b1;

      // burst walks: both orders, every start, both strobes
      for (int mode = 0; mode < 2; mode++) begin
         order_sel = mode[0];
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a;
            a = 16'hA5C0 ^ AW'(s * 16'h1234) | AW'(s);
            a[1:0] = s[1:0];
            if (s[0]) cyc(0, 1, 0, 1, 0, 1, a, "R1 ctl capture");
            else      cyc(0, 1, 0, 0, 0, 1, a, "R2 dual capture");
            for (int n = 0; n < 6; n++)
               cyc(1, 0, 1, 1, 1, 0, 16'hFFFF,
                   mode == 0 ? "R5 R7 linear" : "R6 R7 interleaved");
            cyc(1, 0, 1, 1, 1, 1, 16'h0000, "R8 hold");
            cyc(1, 0, 1, 1, 1, 1, 16'h1111, "R8 hold again");
         end
      end

      // strobe / chip-select sweep from a known mid-burst state
      order_sel = 1'b0;
      for (int e = 0; e < 8; e++) begin
         for (int st = 0; st < 4; st++) begin
            for (int adv = 0; adv < 2; adv++) begin
               cyc(0, 1, 0, 1, 0, 1, 16'h3C3E, "R1 setup");
               cyc(1, 1, 1, 1, 1, 0, 16'h0000, "R5 setup step");
               cyc(e[2], e[1], e[0], st[1], st[0], adv[0], 16'h9A51,
                   (e[2] && st[0]) ? "R3 cpu gated" :
                   ((!e[2] && e[1] && !e[0]) ? "R1 R2 sweep" : "R9 deselect sweep"));
               cyc(1, 0, 1, 1, 1, 0, 16'h7777, "R9 R5 follow-up advance");
            end
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule